// File: doc/BRIEF.md
# 17x17 Multiply-Accumulate Unit

This block is the arithmetic core of a fixed-point signal-processing datapath. Each enabled cycle it takes two 16-bit data words and widens each one to 17 bits. A word is widened as a signed value or as an unsigned value, chosen per operand. The block multiplies the two 17-bit values and then adds the product to, or subtracts it from, a 40-bit accumulator value supplied by the caller. The whole multiply and add completes in a single clock. The result and an overflow flag are registered.

A 16-bit holding register can stand in for the second operand, which suits coefficient-times-sample loops. A fractional mode doubles the product, which removes the duplicated sign bit of Q15 times Q15 arithmetic. Two independent clamps are available. The first limits the single fractional product that cannot be represented. The second limits the accumulated sum to the 40-bit signed range.

Top module: `mac17_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `acc_out` becomes 0, `ovf` becomes 0 and the holding register becomes 0.
- R2: Each 16-bit operand is widened to 17 bits. When its signed select is 1, the new top bit copies bit 15. When its signed select is 0, the new top bit is 0. For example, 0xFFFF is read as -1 when signed and as 65535 when unsigned.
- R3: When `t_load` is 1 at a clock edge, the holding register takes `t_din`. When `use_t` is 1, the holding register replaces `y_in` as the second operand, and `y_signed` still selects how it is widened. An operation in the same cycle as a load uses the value the register held before that load.
- R4: With `frac_en`=1 and `sat_mul`=1, a product of two widened operands that both equal -32768 becomes 0x007FFFFFFF instead of 0x0080000000. No other product is clamped.
- R5: With `frac_en`=1, the product is multiplied by two before it is accumulated.
- R6: The product is sign-extended to 40 bits. With `sub_en`=0 the result is `acc_in` plus the product; with `sub_en`=1 it is `acc_in` minus the product. With `sat_acc`=0 the result wraps modulo 2^40.
- R7: With `sat_acc`=1, a result above the 40-bit signed range gives 0x7FFFFFFFFF, and a result below that range gives 0x8000000000.
- R8: `acc_out` and `ovf` update only on a clock edge where `en` is 1. While `en` is 0, both keep their values.
- R9: On each enabled operation, `ovf` is set to 1 if the exact result lies outside the 40-bit signed range, and is cleared to 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Register the result of this cycle's operation |
| t_load | input | 1 | Load the holding register from `t_din` |
| t_din | input | 16 | Holding register load data |
| use_t | input | 1 | Select the holding register as the second operand |
| x_in | input | 16 | First operand |
| y_in | input | 16 | Second operand |
| x_signed | input | 1 | First operand is signed |
| y_signed | input | 1 | Second operand is signed |
| frac_en | input | 1 | Double the product |
| sat_mul | input | 1 | Clamp the fractional -1 times -1 product |
| sub_en | input | 1 | Subtract the product instead of adding it |
| sat_acc | input | 1 | Saturate the accumulated result |
| acc_in | input | 40 | Accumulator value to combine with the product |
| acc_out | output | 40 | Registered accumulated result |
| ovf | output | 1 | Registered overflow of the exact result |

## Verification
Some properties are checked on every clock. These are: the holding register takes its load data; outputs hold while disabled; a saturated overflow lands on one of the two limits; a wrapped overflow flips the sign relative to `acc_in`; a doubled product stays even unless it is clamped; and the -1 times -1 clamp produces its fixed value. The exact arithmetic values can only be shown by the bench's scenarios. These cover the signed and unsigned widening, subtraction, the fractional doubling, the choice of saturation limit and the clearing of the flag. The scenarios also show that an operation in the same cycle as a load sees the old holding value.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ACC_W  = 40;

  typedef struct packed {
    logic frac;
    logic sat_mul;
    logic sub;
    logic sat_acc;
  } mac_ctrl_t;
endpackage

// File: rtl/mac_opnd_ext.sv
module mac_opnd_ext #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] din,
  input  logic          is_signed,
  output logic [DW:0]   dout
);
  // R2: top bit copies the sign bit only for signed operands
  assign dout = {is_signed & din[DW-1], din};
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int unsigned DW = 16,
  localparam int unsigned OW = DW + 1,
  localparam int unsigned RW = 2 * OW,
  localparam int unsigned PW = RW + 1
) (
  input  logic [OW-1:0] opa,
  input  logic [OW-1:0] opb,
  input  logic          frac,
  input  logic          sat_mul,
  output logic [PW-1:0] prod,
  output logic          clamped
);
  localparam logic [OW-1:0] MIN_OP  = {2'b11, {(DW-1){1'b0}}};
  localparam logic [PW-1:0] SAT_VAL = {{(PW-2*DW+1){1'b0}}, {(2*DW-1){1'b1}}};

  logic [RW-1:0] ext_a, ext_b, raw;
  logic [PW-1:0] scaled;

  // sign-extend both operands to full product width; low bits of the
  // unsigned product then equal the two's-complement product
  assign ext_a = {{OW{opa[OW-1]}}, opa};
  assign ext_b = {{OW{opb[OW-1]}}, opb};
  assign raw   = ext_a * ext_b;

  // R5: fractional mode doubles the product
  assign scaled  = frac ? {raw, 1'b0} : {raw[RW-1], raw};
  // R4: only -1 * -1 in fractional form is out of range
  assign clamped = frac & sat_mul & (opa == MIN_OP) & (opb == MIN_OP);
  assign prod    = clamped ? SAT_VAL : scaled;
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int unsigned PW = 35,
  parameter int unsigned AW = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] acc_in,
  input  logic [PW-1:0] prod,
  input  logic          sub,
  input  logic          sat_acc,
  output logic [AW-1:0] acc_out,
  output logic          ovf
);
  localparam logic [AW-1:0] POS_LIM = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] NEG_LIM = {1'b1, {(AW-1){1'b0}}};

  logic [AW-1:0] prod_ext;
  logic [AW:0]   wide_a, wide_p, sum;
  logic          of;
  logic [AW-1:0] res;

  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
  assign wide_a   = {acc_in[AW-1], acc_in};
  assign wide_p   = {prod_ext[AW-1], prod_ext};
  assign sum      = sub ? (wide_a - wide_p) : (wide_a + wide_p);
  assign of       = sum[AW] ^ sum[AW-1];

  always_comb begin
    res = sum[AW-1:0];
    if (of && sat_acc) res = sum[AW] ? NEG_LIM : POS_LIM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out <= '0;
      ovf     <= 1'b0;
    end else if (en) begin
      acc_out <= res;
      ovf     <= of;
    end
  end

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(acc_out) && $stable(ovf)));

  a_r7_clamp_limits: assert property (@(posedge clk) disable iff (rst)
    (en && sat_acc) |=> (!ovf || acc_out == POS_LIM || acc_out == NEG_LIM));

  a_r6_wrap_flips_sign: assert property (@(posedge clk) disable iff (rst)
    (en && !sat_acc) |=> (!ovf || (acc_out[AW-1] != $past(acc_in[AW-1]))));
endmodule

// File: rtl/mac17_unit.sv
module mac17_unit #(
  parameter int unsigned DW = mac_pkg::DATA_W,
  parameter int unsigned AW = mac_pkg::ACC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          t_load,
  input  logic [DW-1:0] t_din,
  input  logic          use_t,
  input  logic [DW-1:0] x_in,
  input  logic [DW-1:0] y_in,
  input  logic          x_signed,
  input  logic          y_signed,
  input  logic          frac_en,
  input  logic          sat_mul,
  input  logic          sub_en,
  input  logic          sat_acc,
  input  logic [AW-1:0] acc_in,
  output logic [AW-1:0] acc_out,
  output logic          ovf
);
  localparam int unsigned OW = DW + 1;
  localparam int unsigned PW = 2 * OW + 1;

  mac_pkg::mac_ctrl_t ctrl;
  logic [DW-1:0] t_reg;
  logic [DW-1:0] b_sel;
  logic [OW-1:0] opa, opb;
  logic [PW-1:0] prod;
  logic          clamped;

  assign ctrl = '{frac: frac_en, sat_mul: sat_mul, sub: sub_en, sat_acc: sat_acc};

  // R3: holding register, read before this edge's load
  always_ff @(posedge clk) begin
    if (rst)         t_reg <= '0;
    else if (t_load) t_reg <= t_din;
  end

  assign b_sel = use_t ? t_reg : y_in;

  mac_opnd_ext #(.DW(DW)) u_ext_a (.din(x_in),  .is_signed(x_signed), .dout(opa));
  mac_opnd_ext #(.DW(DW)) u_ext_b (.din(b_sel), .is_signed(y_signed), .dout(opb));

  mac_mult #(.DW(DW)) u_mult (
    .opa(opa), .opb(opb), .frac(ctrl.frac), .sat_mul(ctrl.sat_mul),
    .prod(prod), .clamped(clamped)
  );

  mac_accum #(.PW(PW), .AW(AW)) u_accum (
    .clk(clk), .rst(rst), .en(en), .acc_in(acc_in), .prod(prod),
    .sub(ctrl.sub), .sat_acc(ctrl.sat_acc), .acc_out(acc_out), .ovf(ovf)
  );

  a_r3_t_capture: assert property (@(posedge clk) disable iff (rst)
    t_load |=> (t_reg == $past(t_din)));

  a_r4_frac_clamp_value: assert property (@(posedge clk) disable iff (rst)
    (frac_en && sat_mul && x_signed && y_signed &&
     x_in == {1'b1, {(DW-1){1'b0}}} && b_sel == {1'b1, {(DW-1){1'b0}}})
    |-> (prod == {{(PW-2*DW+1){1'b0}}, {(2*DW-1){1'b1}}}));

  a_r5_frac_even: assert property (@(posedge clk) disable iff (rst)
    (frac_en && !clamped) |-> (prod[0] == 1'b0));
endmodule

// File: tb/mac17_unit_tb.sv
module mac17_unit_tb;
  logic        clk = 1'b0;
  logic        rst, en, t_load, use_t, x_signed, y_signed;
  logic        frac_en, sat_mul, sub_en, sat_acc;
  logic [15:0] t_din, x_in, y_in;
  logic [39:0] acc_in, acc_out;
  logic        ovf;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  mac17_unit u_dut (
    .clk(clk), .rst(rst), .en(en), .t_load(t_load), .t_din(t_din), .use_t(use_t),
    .x_in(x_in), .y_in(y_in), .x_signed(x_signed), .y_signed(y_signed),
    .frac_en(frac_en), .sat_mul(sat_mul), .sub_en(sub_en), .sat_acc(sat_acc),
    .acc_in(acc_in), .acc_out(acc_out), .ovf(ovf)
  );

  typedef struct packed {
    logic [15:0] x;
    logic [15:0] y;
    logic        xs, ys, fr, sm, sb, sa;
    logic [39:0] acc;
    logic [39:0] exp_acc;
    logic        exp_ovf;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{16'h0003, 16'h0004, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 40'h000000000A, 40'h0000000016, 1'b0, 8'd6}, // R6 add
    '{16'hFFFF, 16'h0005, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 40'h0000000000, 40'hFFFFFFFFFB, 1'b0, 8'd2}, // R2 signed -1
    '{16'hFFFF, 16'h0002, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 40'h0000000000, 40'h000001FFFE, 1'b0, 8'd2}, // R2 unsigned
    '{16'hFFFF, 16'hFFFF, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 40'h0000000000, 40'h00FFFE0001, 1'b0, 8'd2}, // R2 both unsigned
    '{16'h4000, 16'h4000, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 40'h0000000000, 40'h0020000000, 1'b0, 8'd5}, // R5 doubling
    '{16'h0003, 16'h0004, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 40'h0000000064, 40'h0000000058, 1'b0, 8'd6}, // R6 subtract
    '{16'h8000, 16'h8000, 1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 40'h0000000000, 40'h007FFFFFFF, 1'b0, 8'd4}, // R4 clamp
    '{16'h8000, 16'h8000, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 40'h0000000000, 40'h0080000000, 1'b0, 8'd4}, // R4 no clamp
    '{16'h8000, 16'h8000, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 40'h0000000000, 40'hFF80000000, 1'b0, 8'd4}, // R4 not both -1
    '{16'h0001, 16'h0001, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 40'h7FFFFFFFFF, 40'h8000000000, 1'b1, 8'd6}, // R6 wrap
    '{16'h0001, 16'h0001, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 40'h7FFFFFFFFF, 40'h7FFFFFFFFF, 1'b1, 8'd7}, // R7 upper
    '{16'h0001, 16'h0001, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b1, 40'h8000000000, 40'h8000000000, 1'b1, 8'd7}, // R7 lower
    '{16'h0000, 16'h0000, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 40'h0000000005, 40'h0000000005, 1'b0, 8'd9}  // R9 clear
  };

  task automatic check(input string req, input logic [39:0] a, input logic [39:0] e,
                       input logic ao, input logic eo);
    n_run++;
    if (a !== e || ao !== eo) begin
      n_fail++;
      $display("FAIL %s: acc_out=%h ovf=%b expected acc_out=%h ovf=%b", req, a, ao, e, eo);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; t_load = 1'b0; t_din = '0; use_t = 1'b0;
    x_in = '0; y_in = '0; x_signed = 1'b1; y_signed = 1'b1;
    frac_en = 1'b0; sat_mul = 1'b0; sub_en = 1'b0; sat_acc = 1'b0; acc_in = '0;
    repeat (3) @(negedge clk);
    check("R1", acc_out, 40'h0, ovf, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      x_in = VEC[i].x; y_in = VEC[i].y; x_signed = VEC[i].xs; y_signed = VEC[i].ys;
      frac_en = VEC[i].fr; sat_mul = VEC[i].sm; sub_en = VEC[i].sb; sat_acc = VEC[i].sa;
      acc_in = VEC[i].acc; en = 1'b1;
      step();
      check($sformatf("R%0d", VEC[i].req), acc_out, VEC[i].exp_acc, ovf, VEC[i].exp_ovf);
    end

    // R3: same-cycle load sees old holding value (0 after reset)
    x_signed = 1'b1; y_signed = 1'b1; frac_en = 1'b0; sat_mul = 1'b0;
    sub_en = 1'b0; sat_acc = 1'b0; acc_in = '0;
    t_load = 1'b1; t_din = 16'h0007; use_t = 1'b1; x_in = 16'h0002; y_in = 16'h0064;
    step();
    check("R3", acc_out, 40'h0, ovf, 1'b0);
    t_load = 1'b0; t_din = 16'h0000;
    step();
    check("R3", acc_out, 40'h000000000E, ovf, 1'b0);
    // R3: holding value widened per y_signed
    t_load = 1'b1; t_din = 16'hFFFF; step();
    t_load = 1'b0; y_signed = 1'b0; x_in = 16'h0001; step();
    check("R3", acc_out, 40'h000000FFFF, ovf, 1'b0);
    use_t = 1'b0; y_signed = 1'b1;

    // R8: overflow result, then idle with changed inputs holds both outputs
    x_in = 16'h0001; y_in = 16'h0001; acc_in = 40'h7FFFFFFFFF; step();
    check("R8", acc_out, 40'h8000000000, ovf, 1'b1);
    en = 1'b0; acc_in = 40'h0000000123; x_in = 16'h0000;
    step(); step();
    check("R8", acc_out, 40'h8000000000, ovf, 1'b1);

    // R1: reset mid-run clears outputs and the holding register
    rst = 1'b1; step(); rst = 1'b0;
    check("R1", acc_out, 40'h0, ovf, 1'b0);
    en = 1'b1; use_t = 1'b1; x_in = 16'h0005; acc_in = 40'h0000000003; step();
    check("R1", acc_out, 40'h0000000003, ovf, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule